// File: doc/BRIEF.md
# Privilege-Aware Interrupt Priority Selector

This block keeps one pending flag for each of seven processor interrupt sources and, every cycle, names the single source that would be delivered next. The choice depends on the privilege mode, the global interrupt enable, the trap level with its own enable, the hypervisor interrupt-pending bit, the software-interrupt register and the processor interrupt level. The priority order changes between hyperprivileged and normal mode. A software interrupt competes through its level, which is the highest set bit of the software-interrupt register. The platform vector interrupt preempts software levels below 6 only.

Sources are posted by one-cycle strobes. The selection is combinational from the registered flags and the state inputs. A consumer takes the selected interrupt by raising `take_i` while `sel_valid_o` is high. On that clock edge the selected flag is cleared. The exception is a software interrupt whose register still has other level bits set: its flag stays pending.

Top module: `intr_prio_sel`

## Requirements
- R1: After reset no source is pending. `any_pend_o` and `sel_valid_o` are low, `sel_onehot_o` is 0 and `sel_code_o` is 0. Source codes and post bit positions are: trap-level-zero 0, tick match 1, platform vector 2, cpu message 3, device message 4, resumable error 5, soft interrupt 6.
- R2: Posting a source that is already pending adds nothing. After one delivery of that source, `any_pend_o` is low if no other source is pending. `any_pend_o` is high whenever any flag is pending.
- R3: In hyperprivileged mode with the enable set, tick match is chosen first, but only when the hypervisor pending bit is 1. The platform vector is chosen next. No other source is eligible.
- R4: In hyperprivileged mode with the enable clear, nothing is selected, even with a tick match pending and the hypervisor pending bit set.
- R5: In normal mode, trap-level-zero is chosen first when its enable is set and the trap level is 0. It ranks above tick match, which also needs the hypervisor pending bit.
- R6: In normal mode with the enable set, the order after tick match is cpu message, device message, soft interrupt, resumable error. With the enable clear, none of these four is chosen.
- R7: The soft level is the index of the highest set bit among bits 15..1 of the software-interrupt register, or 0 if none is set. With a soft interrupt pending, a level below 6 and the platform vector pending, the vector is chosen in the soft slot.
- R8: Otherwise a soft interrupt is chosen only when its level is strictly greater than the processor interrupt level, and `soft_lvl_o` then shows that level. If the level does not exceed it, selection falls through to resumable error.
- R9: A take of a soft interrupt leaves its flag pending while other level bits remain set in the register. A take of any other selection clears that flag.
- R10: A post and a take of the same source in one cycle leave it pending. When nothing is eligible, `sel_valid_o` is low and both selection outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| post_i | input | 7 | One-cycle post strobe per source, bit index = source code |
| hpriv_i | input | 1 | Hyperprivileged mode |
| ie_i | input | 1 | Global interrupt enable |
| tlz_en_i | input | 1 | Trap-level-zero interrupt enable |
| trap_lvl_i | input | 3 | Current trap level |
| hyp_pend_i | input | 1 | Bit 0 of the hypervisor interrupt-pending register |
| softint_i | input | 16 | Software-interrupt register; bit 0 ignored |
| pil_i | input | 4 | Processor interrupt level |
| take_i | input | 1 | Consumer takes the current selection |
| any_pend_o | output | 1 | At least one source pending |
| sel_valid_o | output | 1 | A source is eligible this cycle |
| sel_onehot_o | output | 7 | One-hot selected source |
| sel_code_o | output | 3 | Encoded selected source |
| soft_lvl_o | output | 4 | Soft level when a soft interrupt is selected, else 0 |

## Verification
Each scenario posts a chosen mix of sources and then changes one state input at a time. Holding the pending set fixed and flipping the hypervisor pending bit, the enables or the trap level shows whether each gate filters exactly one source. Soft-interrupt patterns put the level on both sides of 6 and on both sides of the processor level, with and without a pending vector. These separate the vector-preempt path, the level comparison and the fall-through to resumable error. Taking a soft interrupt with one and with several level bits set shows the conditional clear, and re-posts and same-cycle post-with-take show that the pending state never counts twice or drops.

// File: rtl/intr_prio_pkg.sv
package intr_prio_pkg;
    localparam int NSRC  = 7;
    localparam int CW    = $clog2(NSRC);
    localparam int SWI_W = 16;
    localparam int LVL_W = $clog2(SWI_W);
    localparam int TL_W  = 3;
    localparam int VEC_LVL_LIMIT = 6;

    typedef enum logic [CW-1:0] {
        SRC_TLZ  = 3'd0,
        SRC_HTK  = 3'd1,
        SRC_VEC  = 3'd2,
        SRC_CMSG = 3'd3,
        SRC_DMSG = 3'd4,
        SRC_RERR = 3'd5,
        SRC_SOFT = 3'd6
    } src_e;

    typedef struct packed {
        logic             valid;
        src_e             code;
        logic [LVL_W-1:0] lvl;
    } pick_t;

    function automatic logic [LVL_W-1:0] top_level(input logic [SWI_W-1:0] v);
        logic [LVL_W-1:0] r;
        r = '0;
        for (int i = 1; i < SWI_W; i++)
            if (v[i]) r = LVL_W'(i);
        return r;
    endfunction
endpackage

// File: rtl/intr_pend_flags.sv
module intr_pend_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] flags_o
);
    always_ff @(posedge clk) begin
        if (rst) flags_o <= '0;
        else     flags_o <= (flags_o & ~clr_i) | set_i;
    end
endmodule

// File: rtl/intr_soft_lvl.sv
module intr_soft_lvl
    import intr_prio_pkg::*;
(
    input  logic [SWI_W-1:0] softint_i,
    output logic [LVL_W-1:0] lvl_o,
    output logic             more_o
);
    logic [SWI_W-1:0] rest;
    always_comb begin
        lvl_o = top_level(softint_i);
        rest  = softint_i;
        rest[0] = 1'b0;
        rest[lvl_o] = 1'b0;
        more_o = |rest;
    end
endmodule

// File: rtl/intr_pick.sv
module intr_pick
    import intr_prio_pkg::*;
(
    input  logic [NSRC-1:0]  flags_i,
    input  logic             hpriv_i,
    input  logic             ie_i,
    input  logic             tlz_en_i,
    input  logic [TL_W-1:0]  trap_lvl_i,
    input  logic             hyp_pend_i,
    input  logic [LVL_W-1:0] soft_lvl_i,
    input  logic [LVL_W-1:0] pil_i,
    output pick_t            pick_o
);
    function automatic pick_t mk(input src_e c, input logic [LVL_W-1:0] l);
        pick_t p;
        p.valid = 1'b1;
        p.code  = c;
        p.lvl   = l;
        return p;
    endfunction

    logic htk_ok;
    assign htk_ok = flags_i[SRC_HTK] && hyp_pend_i;

    always_comb begin
        pick_o = '0;
        if (hpriv_i) begin
            if (ie_i) begin
                if (htk_ok)                pick_o = mk(SRC_HTK, '0);
                else if (flags_i[SRC_VEC]) pick_o = mk(SRC_VEC, '0);
            end
        end else begin
            if (flags_i[SRC_TLZ] && tlz_en_i && trap_lvl_i == '0)
                pick_o = mk(SRC_TLZ, '0);
            else if (htk_ok)
                pick_o = mk(SRC_HTK, '0);
            else if (ie_i) begin
                if (flags_i[SRC_CMSG])
                    pick_o = mk(SRC_CMSG, '0);
                else if (flags_i[SRC_DMSG])
                    pick_o = mk(SRC_DMSG, '0);
                else if (flags_i[SRC_SOFT] && soft_lvl_i < LVL_W'(VEC_LVL_LIMIT)
                         && flags_i[SRC_VEC])
                    pick_o = mk(SRC_VEC, '0);
                else if (flags_i[SRC_SOFT] && soft_lvl_i > pil_i)
                    pick_o = mk(SRC_SOFT, soft_lvl_i);
                else if (flags_i[SRC_RERR])
                    pick_o = mk(SRC_RERR, '0);
            end
        end
    end
endmodule

// File: rtl/intr_prio_sel.sv
module intr_prio_sel
    import intr_prio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  post_i,
    input  logic             hpriv_i,
    input  logic             ie_i,
    input  logic             tlz_en_i,
    input  logic [TL_W-1:0]  trap_lvl_i,
    input  logic             hyp_pend_i,
    input  logic [SWI_W-1:0] softint_i,
    input  logic [LVL_W-1:0] pil_i,
    input  logic             take_i,
    output logic             any_pend_o,
    output logic             sel_valid_o,
    output logic [NSRC-1:0]  sel_onehot_o,
    output logic [CW-1:0]    sel_code_o,
    output logic [LVL_W-1:0] soft_lvl_o
);
    logic [NSRC-1:0]  flags;
    logic [NSRC-1:0]  clr;
    logic [LVL_W-1:0] lvl;
    logic             more;
    pick_t            pick;

    intr_soft_lvl u_lvl (
        .softint_i (softint_i),
        .lvl_o     (lvl),
        .more_o    (more)
    );

    intr_pick u_pick (
        .flags_i    (flags),
        .hpriv_i    (hpriv_i),
        .ie_i       (ie_i),
        .tlz_en_i   (tlz_en_i),
        .trap_lvl_i (trap_lvl_i),
        .hyp_pend_i (hyp_pend_i),
        .soft_lvl_i (lvl),
        .pil_i      (pil_i),
        .pick_o     (pick)
    );

    always_comb begin
        sel_onehot_o = '0;
        if (pick.valid) sel_onehot_o[pick.code] = 1'b1;
        clr = '0;
        if (take_i && pick.valid && !(pick.code == SRC_SOFT && more))
            clr = sel_onehot_o;
    end

    intr_pend_flags #(.N(NSRC)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_i   (post_i),
        .clr_i   (clr),
        .flags_o (flags)
    );

    assign any_pend_o  = |flags;
    assign sel_valid_o = pick.valid;
    assign sel_code_o  = pick.code;
    assign soft_lvl_o  = pick.lvl;
endmodule

// File: rtl/intr_prio_sel_chk.sv
module intr_prio_sel_chk
    import intr_prio_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [NSRC-1:0]  post_i,
    input logic             hpriv_i,
    input logic             ie_i,
    input logic             tlz_en_i,
    input logic [TL_W-1:0]  trap_lvl_i,
    input logic [LVL_W-1:0] pil_i,
    input logic             any_pend_o,
    input logic             sel_valid_o,
    input logic [NSRC-1:0]  sel_onehot_o,
    input logic [CW-1:0]    sel_code_o,
    input logic [LVL_W-1:0] soft_lvl_o
);
    // R4
    hpriv_off_chk: assert property (@(posedge clk) disable iff (rst)
        (hpriv_i && !ie_i) |-> !sel_valid_o);

    // R5
    tlz_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_valid_o && sel_code_o == CW'(SRC_TLZ)) |-> (tlz_en_i && !hpriv_i && trap_lvl_i == '0));

    // R8
    soft_above_pil_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_valid_o && sel_code_o == CW'(SRC_SOFT)) |-> (soft_lvl_o > pil_i));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !sel_valid_o |-> (sel_onehot_o == '0 && sel_code_o == '0 && soft_lvl_o == '0));

    // R2
    no_spont_pend_chk: assert property (@(posedge clk) disable iff (rst)
        (!any_pend_o && post_i == '0) |=> !any_pend_o);

    // R6
    valid_needs_pend_chk: assert property (@(posedge clk) disable iff (rst)
        sel_valid_o |-> (any_pend_o && $countones(sel_onehot_o) == 1));
endmodule

bind intr_prio_sel intr_prio_sel_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .post_i       (post_i),
    .hpriv_i      (hpriv_i),
    .ie_i         (ie_i),
    .tlz_en_i     (tlz_en_i),
    .trap_lvl_i   (trap_lvl_i),
    .pil_i        (pil_i),
    .any_pend_o   (any_pend_o),
    .sel_valid_o  (sel_valid_o),
    .sel_onehot_o (sel_onehot_o),
    .sel_code_o   (sel_code_o),
    .soft_lvl_o   (soft_lvl_o)
);

// File: tb/intr_prio_sel_tb.sv
module intr_prio_sel_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic [6:0]  post_i;
    logic        hpriv_i, ie_i, tlz_en_i, hyp_pend_i, take_i;
    logic [2:0]  trap_lvl_i;
    logic [15:0] softint_i;
    logic [3:0]  pil_i;
    logic        any_pend_o, sel_valid_o;
    logic [6:0]  sel_onehot_o;
    logic [2:0]  sel_code_o;
    logic [3:0]  soft_lvl_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    intr_prio_sel u_dut (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Selection check: valid, code, one-hot, level
    task automatic chk_sel(input string req, input bit v, input int code, input int lvl);
        #1;
        chk({req, " valid"}, int'(sel_valid_o), int'(v));
        chk({req, " code"}, int'(sel_code_o), v ? code : 0);
        chk({req, " onehot"}, int'(sel_onehot_o), v ? (1 << code) : 0);
        chk({req, " level"}, int'(soft_lvl_o), lvl);
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic post(input logic [6:0] m);
        post_i = m; cyc(); post_i = '0;
    endtask

    task automatic take();
        take_i = 1'b1; cyc(); take_i = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1; post_i = '0; take_i = 1'b0;
        hpriv_i = 0; ie_i = 0; tlz_en_i = 0; hyp_pend_i = 0;
        trap_lvl_i = 0; softint_i = '0; pil_i = '0;
        cyc(); cyc(); rst = 1'b0; cyc();
    endtask

    task automatic t_reset();
        do_reset();
        #1;
        chk("R1 any_pend", int'(any_pend_o), 0);
        chk_sel("R1 idle", 0, 0, 0);
    endtask

    task automatic t_repost();
        do_reset();
        ie_i = 1;
        post(7'b000_1000); post(7'b000_1000);
        chk_sel("R2 cmsg", 1, 3, 0);
        take();
        #1 chk("R2 pend after one take", int'(any_pend_o), 0);
        chk_sel("R10 none eligible", 0, 0, 0);
    endtask

    task automatic t_hpriv_on();
        do_reset();
        hpriv_i = 1; ie_i = 1;
        post(7'b111_1111);
        hyp_pend_i = 0; cyc();
        chk_sel("R3 vector without hyp bit", 1, 2, 0);
        hyp_pend_i = 1; cyc();
        chk_sel("R3 tick first", 1, 1, 0);
        take();
        chk_sel("R3 vector after tick", 1, 2, 0);
        take();
        chk_sel("R3 others ineligible", 0, 0, 0);
    endtask

    task automatic t_hpriv_off();
        do_reset();
        hpriv_i = 1; ie_i = 0; hyp_pend_i = 1;
        post(7'b000_0110);
        chk_sel("R4 disabled in hpriv", 0, 0, 0);
        #1 chk("R4 still pending", int'(any_pend_o), 1);
    endtask

    task automatic t_tlz();
        do_reset();
        ie_i = 1; hyp_pend_i = 1;
        post(7'b000_0011);
        tlz_en_i = 0; cyc();
        chk_sel("R5 tlz enable off", 1, 1, 0);
        tlz_en_i = 1; trap_lvl_i = 3'd2; cyc();
        chk_sel("R5 trap level nonzero", 1, 1, 0);
        trap_lvl_i = 3'd0; cyc();
        chk_sel("R5 tlz above tick", 1, 0, 0);
    endtask

    task automatic t_order();
        do_reset();
        ie_i = 0;
        post(7'b011_1000);
        chk_sel("R6 disabled", 0, 0, 0);
        ie_i = 1; cyc();
        chk_sel("R6 cmsg first", 1, 3, 0);
        take();
        chk_sel("R6 dmsg second", 1, 4, 0);
        take();
        chk_sel("R6 rerr last", 1, 5, 0);
        take();
        #1 chk("R6 drained", int'(any_pend_o), 0);
    endtask

    task automatic t_soft();
        do_reset();
        ie_i = 1; pil_i = 4'd4;
        softint_i = 16'h0209;       // levels 9 and 3, bit 0 ignored
        post(7'b110_0000);
        chk_sel("R8 soft over rerr", 1, 6, 9);
        take();
        chk_sel("R9 soft still pending", 1, 6, 9);
        softint_i = 16'h0200; cyc();
        take();
        chk_sel("R9 soft cleared -> rerr", 1, 5, 0);
        softint_i = 16'h0001; post(7'b100_0000);
        chk_sel("R7 level 0 below pil", 1, 5, 0);
    endtask

    task automatic t_vec();
        do_reset();
        ie_i = 1; pil_i = 4'd3;
        softint_i = 16'h0020;       // level 5
        post(7'b100_0100);
        chk_sel("R7 vector preempts level 5", 1, 2, 0);
        softint_i = 16'h0080; cyc();  // level 7
        chk_sel("R7 level 7 beats vector", 1, 6, 7);
        pil_i = 4'd7; cyc();
        chk_sel("R8 level equal pil", 0, 0, 0);
    endtask

    task automatic t_post_take();
        do_reset();
        ie_i = 1;
        post(7'b001_0000);
        post_i = 7'b001_0000; take_i = 1'b1; cyc(); post_i = '0; take_i = 1'b0;
        chk_sel("R10 post with take keeps pending", 1, 4, 0);
        take();
        #1 chk("R10 cleared after plain take", int'(any_pend_o), 0);
    endtask

    initial begin
        t_reset();
        t_repost();
        t_hpriv_on();
        t_hpriv_off();
        t_tlz();
        t_order();
        t_soft();
        t_vec();
        t_post_take();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule